// File: doc/BRIEF.md
# Banked Interrupt Enable and Status Unit

This block holds one interrupt-enable register and one interrupt-status register for each of five localities and drives one shared, level-sensitive interrupt line. Event pulses come from the command engine and the locality arbiter. Each pulse carries a locality tag and a four-bit source vector. An event latches its status bit, and raises the line, only if the tagged locality has enabled that source and its global enable.

Software sees the registers through per-locality windows on a simple access port. It selects a locality, a register and a byte offset, and gives an access size of 1, 2 or 4 bytes. Writes are masked to the addressed byte lanes. Only the locality currently reported as active by the arbiter may change its enable or status register. Status bits are cleared by writing ones. The line drops when such a clear leaves the written locality's status at zero. A read-only vector register returns the configured line number.

Top module: `irq_bank_unit`

## Requirements
- R1: After reset every locality's enable register reads 0x0000_0010 (low-level polarity), every status register reads 0, and `irq` is low.
- R2: The enable register has these source bits: bit0 data available, bit1 status valid, bit2 locality changed, bit3 command ready. An event for locality L sets status bit k of L only when enable bit 31 (global) and enable bit k of L were both set before that clock edge. An accepted event drives `irq` high on the following cycle.
- R3: Events whose locality tag is 5 or more change no register and do not raise the line.
- R4: Enable and status writes are ignored unless `acc_loc` equals `active_loc` and `active_loc` is below 5. An `active_loc` of 5 or more means no locality is active.
- R5: Only enable bits 31, 5:4 (polarity) and 3:0 can be written. All other enable bits read 0.
- R6: The byte mask is 0xFF for `acc_size`=0, 0xFFFF for 1, and all ones for 2 or 3. The write data, ANDed with that mask, and the mask itself are both shifted left by 8×`acc_off`. Bits outside the mask keep their value. Reads return the selected register shifted right by 8×`acc_off`.
- R7: A status write clears every status bit for which the shifted, masked write data has a 1 in bits 3:0. An event accepted in the same cycle sets its bit anyway.
- R8: `irq` goes low one cycle after a status write that has at least one 1 in bits 3:0 and leaves that locality's status at zero, unless an event is accepted in the same cycle. Otherwise `irq` keeps its value until it is raised or lowered.
- R9: The vector register (`acc_sel`=1) reads the parameter IRQ_VEC, which lies between 0 and 15, in every valid locality window. Writes to it have no effect.
- R10: `acc_sel`=0 selects enable, 2 selects status and 3 reads 0. Any read of a locality of 5 or more returns 0, and `rd_data` is 0 when no read is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| active_loc | input | 3 | Locality currently owning the interface; 5 or more means none |
| evt_valid | input | 2 | Event pulse per event port (0 command engine, 1 arbiter) |
| evt_loc | input | 6 | Locality tag per event port, 3 bits each |
| evt_src | input | 8 | Source vector per event port, 4 bits each |
| acc_valid | input | 1 | Register access present this cycle |
| acc_write | input | 1 | 1 write, 0 read |
| acc_loc | input | 3 | Locality window of the access |
| acc_sel | input | 2 | Register select: 0 enable, 1 vector, 2 status, 3 none |
| acc_off | input | 2 | Byte offset inside the 32-bit register |
| acc_size | input | 2 | Access size: 0 one byte, 1 two bytes, 2 or 3 four bytes |
| acc_wdata | input | 32 | Write data, right-aligned |
| rd_data | output | 32 | Read data, combinational |
| irq | output | 1 | Shared registered interrupt line |

## Verification
The hardest case to reach is a status clear and an accepted event for the same locality in the same cycle. Here the event must win, both for the status bit and for the line. The directed part of the bench sets up a pending bit and then presents the clearing write and a fresh event on the same edge. A close variant is a clear that removes only one of two pending bits, so the line must stay high. A long pseudo-random phase follows. It changes the active locality, the byte lanes and the event tags, including invalid ones. A behavioural model checks the line on every cycle and checks every read.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;
  localparam int unsigned REG_W      = 32;
  localparam int unsigned SRC_N      = 4;
  localparam int unsigned GLOBAL_BIT = 31;
  localparam logic [REG_W-1:0] EN_WRITABLE = 32'h8000_003F;
  localparam logic [REG_W-1:0] EN_RESET    = 32'h0000_0010;

  typedef enum logic [1:0] {
    SEL_ENABLE = 2'd0,
    SEL_VECTOR = 2'd1,
    SEL_STATUS = 2'd2,
    SEL_NONE   = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_WORD2 = 2'd3
  } acc_size_e;
endpackage

// File: rtl/irq_lane_mask.sv
module irq_lane_mask
  import irq_bank_pkg::*;
(
  input  logic [1:0]       size,
  input  logic [1:0]       offset,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] lane_mask,
  output logic [REG_W-1:0] lane_data
);
  logic [REG_W-1:0] base;
  logic [4:0]       shamt;

  always_comb begin
    unique case (size)
      SZ_BYTE: base = 32'h0000_00FF;
      SZ_HALF: base = 32'h0000_FFFF;
      default: base = 32'hFFFF_FFFF;
    endcase
    shamt     = {offset, 3'b000};
    lane_mask = base << shamt;
    lane_data = (wdata & base) << shamt;
  end
endmodule

// File: rtl/irq_loc_bank.sv
module irq_loc_bank
  import irq_bank_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_wr,
  input  logic             st_wr,
  input  logic [REG_W-1:0] wdata,
  input  logic [REG_W-1:0] wmask,
  input  logic [SRC_N-1:0] evt_src,
  output logic [REG_W-1:0] en_q,
  output logic [SRC_N-1:0] st_q,
  output logic             raise,
  output logic             lower
);
  logic [REG_W-1:0] en_d;
  logic [SRC_N-1:0] st_d, clr, hit;
  logic             st_ce;

  always_comb begin
    hit   = evt_src & en_q[SRC_N-1:0] & {SRC_N{en_q[GLOBAL_BIT]}};
    clr   = st_wr ? wdata[SRC_N-1:0] : '0;
    st_d  = (st_q & ~clr) | hit;
    en_d  = (en_q & ~wmask) | (wdata & EN_WRITABLE);
    raise = |hit;
    lower = (|clr) && (st_d == '0);
    st_ce = raise || (|clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= EN_RESET;
      st_q <= '0;
    end else begin
      if (en_wr) en_q <= en_d;
      if (st_ce) st_q <= st_d;
    end
  end

  AST_GATED_SET: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((st_q & ~$past(st_q) & ~$past(hit)) == '0)); // R2
  AST_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    st_wr |=> ((st_q & $past(clr) & ~$past(hit)) == '0)); // R7
  AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !en_wr |=> $stable(en_q)); // R4
  AST_LANES_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    en_wr |=> ((en_q & ~$past(wmask)) == ($past(en_q) & ~$past(wmask)))); // R6
endmodule

// File: rtl/irq_bank_unit.sv
module irq_bank_unit
  import irq_bank_pkg::*;
#(
  parameter int unsigned NUM_LOC   = 5,
  parameter int unsigned EVT_PORTS = 2,
  parameter int unsigned IRQ_VEC   = 5,
  localparam int unsigned LOC_W    = $clog2(NUM_LOC + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [LOC_W-1:0]           active_loc,
  input  logic [EVT_PORTS-1:0]       evt_valid,
  input  logic [EVT_PORTS*LOC_W-1:0] evt_loc,
  input  logic [EVT_PORTS*SRC_N-1:0] evt_src,
  input  logic                       acc_valid,
  input  logic                       acc_write,
  input  logic [LOC_W-1:0]           acc_loc,
  input  logic [1:0]                 acc_sel,
  input  logic [1:0]                 acc_off,
  input  logic [1:0]                 acc_size,
  input  logic [REG_W-1:0]           acc_wdata,
  output logic [REG_W-1:0]           rd_data,
  output logic                       irq
);
  logic [1:0]       rst_pipe;
  logic             rst_q;
  logic [REG_W-1:0] lane_mask, lane_data;
  logic             wr_ok;
  logic [NUM_LOC-1:0] en_wr_v, st_wr_v, raise_v, lower_v;
  logic [SRC_N-1:0] evt_for [NUM_LOC];
  logic [REG_W-1:0] en_q_a  [NUM_LOC];
  logic [SRC_N-1:0] st_q_a  [NUM_LOC];
  logic [REG_W-1:0] rd_word;
  logic             irq_d, irq_ce;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q = rst_pipe[1];

  irq_lane_mask u_lanes (
    .size      (acc_size),
    .offset    (acc_off),
    .wdata     (acc_wdata),
    .lane_mask (lane_mask),
    .lane_data (lane_data)
  );

  assign wr_ok = acc_valid && acc_write && (acc_loc == active_loc)
                 && (active_loc < LOC_W'(NUM_LOC));

  for (genvar i = 0; i < NUM_LOC; i++) begin : g_loc
    always_comb begin
      evt_for[i] = '0;
      for (int p = 0; p < EVT_PORTS; p++) begin
        if (evt_valid[p] && (evt_loc[p*LOC_W +: LOC_W] == LOC_W'(i)))
          evt_for[i] = evt_for[i] | evt_src[p*SRC_N +: SRC_N];
      end
      en_wr_v[i] = wr_ok && (acc_loc == LOC_W'(i)) && (acc_sel == SEL_ENABLE);
      st_wr_v[i] = wr_ok && (acc_loc == LOC_W'(i)) && (acc_sel == SEL_STATUS);
    end

    irq_loc_bank u_bank (
      .clk     (clk),
      .rst_n   (rst_q),
      .en_wr   (en_wr_v[i]),
      .st_wr   (st_wr_v[i]),
      .wdata   (lane_data),
      .wmask   (lane_mask),
      .evt_src (evt_for[i]),
      .en_q    (en_q_a[i]),
      .st_q    (st_q_a[i]),
      .raise   (raise_v[i]),
      .lower   (lower_v[i])
    );
  end

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < NUM_LOC; i++) begin
      if (acc_loc == LOC_W'(i)) begin
        unique case (acc_sel)
          SEL_ENABLE: rd_word = en_q_a[i];
          SEL_VECTOR: rd_word = REG_W'(IRQ_VEC);
          SEL_STATUS: rd_word = {{(REG_W-SRC_N){1'b0}}, st_q_a[i]};
          default:    rd_word = '0;
        endcase
      end
    end
    rd_data = (acc_valid && !acc_write) ? (rd_word >> {acc_off, 3'b000}) : '0;
  end

  always_comb begin
    irq_ce = (|raise_v) || (|lower_v);
    irq_d  = |raise_v;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q)      irq <= 1'b0;
    else if (irq_ce) irq <= irq_d;
  end

  initial AST_VEC_RANGE: assert (IRQ_VEC <= 15); // R9

  AST_LINE_RISES: assert property (@(posedge clk) disable iff (!rst_q)
    (|raise_v) |=> irq); // R2
  AST_DROP_NEEDS_CLEAR: assert property (@(posedge clk) disable iff (!rst_q)
    $fell(irq) |-> $past(wr_ok && (acc_sel == SEL_STATUS))); // R8
  AST_STRAY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_q)
    (acc_valid && acc_write && (acc_loc != active_loc)) |-> (en_wr_v == '0 && st_wr_v == '0)); // R4
endmodule

// File: tb/irq_bank_unit_test.sv
`timescale 1ns/1ps
module irq_bank_unit_test;
  localparam int NL = 5;
  localparam int VEC = 5;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  active_loc;
  logic [1:0]  evt_valid;
  logic [5:0]  evt_loc;
  logic [7:0]  evt_src;
  logic        acc_valid, acc_write;
  logic [2:0]  acc_loc;
  logic [1:0]  acc_sel, acc_off, acc_size;
  logic [31:0] acc_wdata;
  logic [31:0] rd_data;
  logic        irq;

  int compared = 0;
  int mismatched = 0;
  bit live = 0;
  bit done = 0;

  logic [31:0] m_en [NL];
  logic [3:0]  m_st [NL];
  logic        m_irq;

  always #2 clk = ~clk;

  irq_bank_unit #(.NUM_LOC(NL), .EVT_PORTS(2), .IRQ_VEC(VEC)) uut (
    .clk(clk), .rst_n(rst_n), .active_loc(active_loc),
    .evt_valid(evt_valid), .evt_loc(evt_loc), .evt_src(evt_src),
    .acc_valid(acc_valid), .acc_write(acc_write), .acc_loc(acc_loc),
    .acc_sel(acc_sel), .acc_off(acc_off), .acc_size(acc_size),
    .acc_wdata(acc_wdata), .rd_data(rd_data), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // behavioural reference, updated on every edge
  always @(posedge clk or negedge rst_n) begin : model
    logic [31:0] old_en [NL];
    logic [31:0] m, d;
    logic [3:0]  clr, hit;
    int          l, t;
    bit          rs, lw;
    if (!rst_n) begin
      for (int i = 0; i < NL; i++) begin m_en[i] = 32'h10; m_st[i] = 4'h0; end
      m_irq = 1'b0;
    end else begin
      for (int i = 0; i < NL; i++) old_en[i] = m_en[i];
      rs = 0; lw = 0; clr = 4'h0; l = 0;
      if (acc_valid && acc_write && acc_loc == active_loc && active_loc < NL) begin
        l = acc_loc;
        m = (acc_size == 0) ? 32'hFF : (acc_size == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
        d = (acc_wdata & m) << (8 * acc_off);
        m = m << (8 * acc_off);
        if (acc_sel == 0) m_en[l] = (m_en[l] & ~m) | (d & 32'h8000_003F);
        if (acc_sel == 2) begin clr = d[3:0]; m_st[l] = m_st[l] & ~clr; end
      end
      for (int p = 0; p < 2; p++) begin
        t = evt_loc[p*3 +: 3];
        if (evt_valid[p] && t < NL) begin
          hit = evt_src[p*4 +: 4] & old_en[t][3:0] & {4{old_en[t][31]}};
          m_st[t] = m_st[t] | hit;
          if (hit != 0) rs = 1;
        end
      end
      if (clr != 0 && m_st[l] == 0) lw = 1;
      if (rs) m_irq = 1'b1;
      else if (lw) m_irq = 1'b0;
    end
  end

  function automatic logic [31:0] exp_read(input logic [2:0] loc, input logic [1:0] sel,
                                           input logic [1:0] off);
    logic [31:0] w;
    w = 32'h0;
    if (loc < NL) begin
      case (sel)
        2'd0: w = m_en[loc];
        2'd1: w = VEC;
        2'd2: w = {28'h0, m_st[loc]};
        default: w = 32'h0;
      endcase
    end
    return w >> (8 * off);
  endfunction

  always @(negedge clk) if (live && !done) check("R8 line vs model", {31'h0, irq}, {31'h0, m_irq});

  task automatic step();
    @(negedge clk);
    acc_valid = 0; acc_write = 0; acc_loc = 0; acc_sel = 0; acc_off = 0; acc_size = 0;
    acc_wdata = 0; evt_valid = 0; evt_loc = 0; evt_src = 0;
  endtask

  task automatic set_wr(input logic [2:0] l, input logic [1:0] s, input logic [1:0] o,
                        input logic [1:0] z, input logic [31:0] d);
    acc_valid = 1; acc_write = 1; acc_loc = l; acc_sel = s; acc_off = o; acc_size = z; acc_wdata = d;
  endtask

  task automatic set_evt(input int p, input logic [2:0] l, input logic [3:0] s);
    evt_valid[p] = 1'b1; evt_loc[p*3 +: 3] = l; evt_src[p*4 +: 4] = s;
  endtask

  task automatic wr(input logic [2:0] l, input logic [1:0] s, input logic [1:0] o,
                    input logic [1:0] z, input logic [31:0] d);
    step(); set_wr(l, s, o, z, d);
  endtask

  task automatic ev(input int p, input logic [2:0] l, input logic [3:0] s);
    step(); set_evt(p, l, s);
  endtask

  task automatic rd_exp(input string req, input logic [2:0] l, input logic [1:0] s,
                        input logic [1:0] o, input logic [31:0] e);
    step();
    acc_valid = 1; acc_write = 0; acc_loc = l; acc_sel = s; acc_off = o;
    #1 check(req, rd_data, e);
  endtask

  initial begin
    #800000;
    if (!done) begin
      done = 1;
      mismatched++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    rst_n = 0; active_loc = 3'd7;
    acc_valid = 0; acc_write = 0; acc_loc = 0; acc_sel = 0; acc_off = 0; acc_size = 0;
    acc_wdata = 0; evt_valid = 0; evt_loc = 0; evt_src = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) step();
    live = 1;

    for (int i = 0; i < NL; i++) begin
      rd_exp("R1 enable reset", 3'(i), 2'd0, 2'd0, 32'h10);
      rd_exp("R1 status reset", 3'(i), 2'd2, 2'd0, 32'h0);
    end
    check("R1 irq reset", {31'h0, irq}, 32'h0);
    rd_exp("R9 vector", 3'd0, 2'd1, 2'd0, VEC);

    wr(3'd0, 2'd0, 2'd0, 2'd2, 32'h8000_000F);
    rd_exp("R4 no active locality", 3'd0, 2'd0, 2'd0, 32'h10);

    active_loc = 3'd0;
    wr(3'd0, 2'd0, 2'd0, 2'd2, 32'hFFFF_FFFF);
    rd_exp("R5 writable bits", 3'd0, 2'd0, 2'd0, 32'h8000_003F);
    wr(3'd0, 2'd0, 2'd0, 2'd2, 32'h0);
    rd_exp("R5 cleared", 3'd0, 2'd0, 2'd0, 32'h0);
    wr(3'd0, 2'd0, 2'd3, 2'd0, 32'hFFFF_FF80);
    rd_exp("R6 byte lane 3", 3'd0, 2'd0, 2'd0, 32'h8000_0000);
    wr(3'd0, 2'd0, 2'd0, 2'd1, 32'hFFFF_0009);
    rd_exp("R6 half lane 0", 3'd0, 2'd0, 2'd0, 32'h8000_0009);
    rd_exp("R6 read offset", 3'd0, 2'd0, 2'd3, 32'h80);

    ev(0, 3'd0, 4'h2);
    rd_exp("R2 disabled source", 3'd0, 2'd2, 2'd0, 32'h0);
    check("R2 line stays low", {31'h0, irq}, 32'h0);
    ev(1, 3'd0, 4'h1);
    rd_exp("R2 enabled source", 3'd0, 2'd2, 2'd0, 32'h1);
    check("R2 line high", {31'h0, irq}, 32'h1);

    ev(0, 3'd5, 4'hF);
    rd_exp("R3 invalid tag", 3'd0, 2'd2, 2'd0, 32'h1);

    wr(3'd1, 2'd0, 2'd0, 2'd2, 32'h8000_000F);
    rd_exp("R4 inactive enable write", 3'd1, 2'd0, 2'd0, 32'h10);

    ev(0, 3'd0, 4'h8);
    rd_exp("R2 command ready", 3'd0, 2'd2, 2'd0, 32'h9);
    wr(3'd0, 2'd2, 2'd0, 2'd2, 32'h1);
    rd_exp("R7 partial clear", 3'd0, 2'd2, 2'd0, 32'h8);
    check("R8 line held", {31'h0, irq}, 32'h1);
    wr(3'd0, 2'd2, 2'd0, 2'd2, 32'h10);
    rd_exp("R8 no source bits", 3'd0, 2'd2, 2'd0, 32'h8);
    check("R8 line held no source", {31'h0, irq}, 32'h1);
    wr(3'd0, 2'd2, 2'd0, 2'd0, 32'h8);
    rd_exp("R7 full clear", 3'd0, 2'd2, 2'd0, 32'h0);
    check("R8 line low", {31'h0, irq}, 32'h0);

    ev(0, 3'd0, 4'h1);
    step(); set_wr(3'd0, 2'd2, 2'd0, 2'd2, 32'h1); set_evt(1, 3'd0, 4'h1);
    rd_exp("R7 event wins", 3'd0, 2'd2, 2'd0, 32'h1);
    check("R8 event wins line", {31'h0, irq}, 32'h1);

    wr(3'd0, 2'd1, 2'd0, 2'd2, 32'hF);
    rd_exp("R9 vector write ignored", 3'd0, 2'd1, 2'd0, VEC);
    rd_exp("R10 select 3", 3'd0, 2'd3, 2'd0, 32'h0);
    rd_exp("R10 invalid locality", 3'd6, 2'd0, 2'd0, 32'h0);

    for (int n = 0; n < 4000; n++) begin
      step();
      if ($urandom % 16 == 0) active_loc = 3'($urandom % 8);
      if ($urandom % 3 == 0) set_evt(0, 3'($urandom % 7), 4'($urandom));
      if ($urandom % 3 == 0) set_evt(1, 3'($urandom % 7), 4'($urandom));
      if ($urandom % 2 == 0) begin
        set_wr(($urandom % 4 == 0) ? 3'($urandom % 8) : active_loc, 2'($urandom),
               2'($urandom), 2'($urandom), (($urandom % 2) != 0) ? 32'h8000_000F : $urandom);
      end else begin
        acc_valid = 1; acc_write = 0; acc_loc = 3'($urandom % 8);
        acc_sel = 2'($urandom); acc_off = 2'($urandom);
        #1 check("R6 random read", rd_data, exp_read(acc_loc, acc_sel, acc_off));
      end
    end
    step();
    step();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule